// File: doc/BRIEF.md
# Weak-Ordering Issue Gate

This block sits on the request path between a processor core and its memory system and makes that path behave as a weakly ordered memory. Every request the core offers is marked as either an ordinary data access or a synchronization access. Data accesses flow through freely and may finish in any order. A synchronization access acts as a fence in both directions. It cannot leave until every data access issued before it has finished. No data access behind it can leave until it has finished.

The gate keeps two pieces of state: a saturating count of data accesses that have been issued but not yet completed, and one flag that marks a synchronization access as in flight. The upstream and downstream ports use a valid/ready handshake and are joined combinationally. The gate only masks the valid and ready signals; it never buffers a request. The memory side reports each completion with a one-cycle strobe and a type bit.

Top module: `wo_issue_gate`

## Requirements
- R1: After reset the outstanding count is zero and no synchronization access is in flight, so a synchronization request (`req_sync`=1) is passed downstream at once.
- R2: When a request is allowed, `mem_valid` follows `req_valid`, `mem_sync` and `mem_payload` copy `req_sync` and `req_payload`, and `req_ready` follows `mem_ready`. When a request is blocked, both `mem_valid` and `req_ready` are 0.
- R3: The count rises by one on each data handshake (`req_valid` and `req_ready` with `req_sync`=0) and falls by one on each data completion (`cpl_valid` with `cpl_sync`=0). When both happen in the same cycle, the count is unchanged.
- R4: A synchronization request is blocked while the registered count is nonzero. A completion that brings the count to zero unblocks it from the next cycle.
- R5: From the cycle after a synchronization handshake, data requests are blocked. A synchronization completion (`cpl_valid` with `cpl_sync`=1) lets data through from the following cycle.
- R6: While a synchronization access is in flight, a further synchronization request is blocked, so synchronization accesses leave one at a time in program order.
- R7: The count saturates at `MAX_OUT`. While it equals `MAX_OUT`, data requests are blocked.
- R8: Data completions carry no identity and may arrive in any order. A data completion that arrives while the count is zero is ignored, so the count does not underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a request |
| req_sync | input | 1 | 1 = synchronization access, 0 = data access |
| req_payload | input | PAYLOAD_W | Opaque request contents |
| req_ready | output | 1 | Request accepted this cycle |
| mem_valid | output | 1 | Request presented to memory |
| mem_sync | output | 1 | Type of the presented request |
| mem_payload | output | PAYLOAD_W | Contents of the presented request |
| mem_ready | input | 1 | Memory accepts the presented request |
| cpl_valid | input | 1 | One-cycle completion strobe |
| cpl_sync | input | 1 | Type of the completed access |

## Verification
The hardest states to reach are the edges of the counter: the saturated value, the zero value hit by a stray completion, and a cycle in which an issue and a completion cancel out. The stimulus builds up outstanding data accesses one handshake at a time with the memory side always ready. It then lines up a completion strobe in the same cycle as a new issue, and checks the count through the cycle in which a waiting fence is released. A smaller `MAX_OUT` is used so saturation is reached within a few cycles.

// File: rtl/wo_issue_gate.sv
module wo_issue_gate #(
  parameter int PAYLOAD_W = 32,
  parameter int MAX_OUT   = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_sync,
  input  logic [PAYLOAD_W-1:0] req_payload,
  output logic                 req_ready,
  output logic                 mem_valid,
  output logic                 mem_sync,
  output logic [PAYLOAD_W-1:0] mem_payload,
  input  logic                 mem_ready,
  input  logic                 cpl_valid,
  input  logic                 cpl_sync
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_OUT);

  logic [CW-1:0] out_cnt;
  logic          fence_busy;
  logic          allow, data_go, sync_go, data_done, sync_done;

  assign allow = !fence_busy && (req_sync ? (out_cnt == '0) : (out_cnt != CMAX));

  assign mem_valid   = req_valid && allow;
  assign mem_sync    = req_sync;
  assign mem_payload = req_payload;
  assign req_ready   = mem_ready && allow;

  assign data_go   = req_valid && req_ready && !req_sync;
  assign sync_go   = req_valid && req_ready && req_sync;
  assign data_done = cpl_valid && !cpl_sync && (out_cnt != '0);
  assign sync_done = cpl_valid && cpl_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cnt    <= '0;
      fence_busy <= 1'b0;
    end else begin
      if (data_go && !data_done)      out_cnt <= out_cnt + 1'b1;
      else if (!data_go && data_done) out_cnt <= out_cnt - 1'b1;
      if (sync_go)        fence_busy <= 1'b1;
      else if (sync_done) fence_busy <= 1'b0;
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CMAX);

  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sync && !cpl_valid) |=> out_cnt == $past(out_cnt) + 1'b1);

  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !cpl_valid) |=> $stable(out_cnt));

  a_r5_fence_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sync) |=> !(mem_valid && !mem_sync));

  a_r6_one_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sync) |=> !(req_valid && req_sync && req_ready));

  a_r2_pass_payload: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_payload == req_payload && mem_sync == req_sync));

  a_r4_sync_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sync) |=> !(mem_valid && mem_sync));
endmodule

// File: tb/test_wo_issue_gate.sv
module test_wo_issue_gate;
  localparam int PW = 8;
  localparam int MX = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_sync = 0, mem_ready = 0, cpl_valid = 0, cpl_sync = 0;
  logic [PW-1:0] req_payload = '0;
  logic req_ready, mem_valid, mem_sync;
  logic [PW-1:0] mem_payload;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wo_issue_gate #(.PAYLOAD_W(PW), .MAX_OUT(MX)) i_wo_issue_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sync(req_sync),
    .req_payload(req_payload), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_sync(mem_sync), .mem_payload(mem_payload), .mem_ready(mem_ready),
    .cpl_valid(cpl_valid), .cpl_sync(cpl_sync));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // next cycle: inputs set 1 ns after the edge, outputs sampled 2 ns later
  task automatic cyc(input logic v, input logic s, input logic [PW-1:0] p,
                     input logic mr, input logic cv, input logic cs);
    @(posedge clk); #1;
    req_valid = v; req_sync = s; req_payload = p; mem_ready = mr;
    cpl_valid = cv; cpl_sync = cs;
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_reset_fence();
    cyc(1, 1, 8'h11, 1, 0, 0);
    chk(req_ready && mem_valid && mem_sync, "R1 sync passes after reset", int'(req_ready), 1);
    cyc(1, 0, 8'h22, 1, 0, 0);
    chk(!mem_valid && !req_ready, "R5 data blocked by fence", int'(mem_valid), 0);
    cyc(1, 1, 8'h23, 1, 0, 0);
    chk(!mem_valid && !req_ready, "R6 second sync blocked", int'(mem_valid), 0);
    cyc(1, 0, 8'h24, 1, 1, 1);
    chk(!mem_valid, "R5 still blocked in completion cycle", int'(mem_valid), 0);
    cyc(1, 0, 8'h25, 0, 0, 0);
    chk(mem_valid && !req_ready && mem_payload == 8'h25 && !mem_sync,
        "R2 data passes after fence done, mem not ready", int'(mem_payload), 'h25);
    idle();
  endtask

  task automatic t_drain();
    cyc(1, 0, 8'h31, 1, 0, 0);
    chk(req_ready, "R2 data 1 accepted", int'(req_ready), 1);
    cyc(1, 0, 8'h32, 1, 0, 0);
    chk(req_ready, "R2 data 2 accepted", int'(req_ready), 1);
    cyc(1, 1, 8'h33, 1, 0, 0);
    chk(!mem_valid && !req_ready, "R4 sync blocked, count 2", int'(mem_valid), 0);
    cyc(1, 1, 8'h33, 1, 1, 0);
    chk(!mem_valid, "R4 sync blocked in completion cycle", int'(mem_valid), 0);
    cyc(1, 1, 8'h33, 1, 1, 0);
    chk(!mem_valid, "R8 sync blocked, count 1", int'(mem_valid), 0);
    cyc(1, 1, 8'h33, 1, 0, 0);
    chk(mem_valid && req_ready && mem_sync, "R4 sync passes once drained", int'(mem_valid), 1);
    cyc(0, 0, 0, 1, 1, 1);
    idle();
  endtask

  task automatic t_same_cycle();
    cyc(1, 0, 8'h41, 1, 0, 0);
    cyc(1, 0, 8'h42, 1, 1, 0);
    chk(req_ready, "R3 issue with completion", int'(req_ready), 1);
    cyc(1, 1, 8'h43, 1, 0, 0);
    chk(!mem_valid, "R3 count held at 1", int'(mem_valid), 0);
    cyc(1, 1, 8'h43, 1, 1, 0);
    cyc(1, 1, 8'h43, 1, 0, 0);
    chk(mem_valid && req_ready, "R3 sync passes after single completion", int'(mem_valid), 1);
    cyc(0, 0, 0, 1, 1, 1);
    idle();
  endtask

  task automatic t_saturate();
    for (int i = 0; i < MX; i++) begin
      cyc(1, 0, PW'(8'h50 + i), 1, 0, 0);
      chk(req_ready, "R7 data accepted below max", int'(req_ready), 1);
    end
    cyc(1, 0, 8'h5F, 1, 0, 0);
    chk(!mem_valid && !req_ready, "R7 data blocked at max", int'(mem_valid), 0);
    cyc(1, 0, 8'h5F, 1, 1, 0);
    chk(!mem_valid, "R7 blocked in completion cycle", int'(mem_valid), 0);
    cyc(1, 0, 8'h5E, 1, 0, 0);
    chk(mem_valid && req_ready && mem_payload == 8'h5E, "R7 data resumes below max", int'(mem_payload), 'h5E);
    for (int i = 0; i < MX; i++) cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 1, 8'h60, 1, 0, 0);
    chk(mem_valid && req_ready, "R8 drained after out-of-order completions", int'(mem_valid), 1);
    cyc(0, 0, 0, 1, 1, 1);
    idle();
  endtask

  task automatic t_underflow();
    cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 1, 8'h70, 0, 0, 0);
    chk(mem_valid && !req_ready, "R8 stray completion ignored", int'(mem_valid), 1);
    idle();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset_fence();
    t_drain();
    t_same_cycle();
    t_saturate();
    t_underflow();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule